// File: doc/BRIEF.md
# Banked Interrupt Pending Controller

This block gathers 72 level-sensitive interrupt request lines and presents them to one processor as a single IRQ line and a single FIQ line. The lines are split into three banks. Two banks hold 32 shared peripheral sources each, and a third bank holds 8 sources that belong to the processor itself. Each source has an enable bit. Software sets enable bits through one set of write-one registers and clears them through a separate set, so no read-modify-write is ever needed. The pending bits are not latched. Each one is the live level of its input, masked by its enable.

Software first reads a basic status word. That word holds the 8 processor-local sources, one summary bit for each shared bank, and copies of eleven chosen shared sources. For those eleven sources, one read of the basic word is enough to find the cause. There is no priority among sources. Instead, one source can be picked out and steered to the FIQ line, which removes it from the IRQ line. The bus is a plain synchronous register port. A write takes effect at the clock edge. A read is combinational on the address.

Top module: `bank_irq_ctrl`

## Requirements
- R1: After reset, every enable bit is 0 and the FIQ steering register is 0. As a result every mapped register reads 0, and `irq_o` and `fiq_o` are low while no source is enabled or steered.
- R2: Source numbering is fixed. Source s (0..31) appears at bit s of offset 0x04. Source s (32..63) appears at bit s-32 of offset 0x08. Source s (64..71) appears at bit s-64 of offset 0x00. Each bit is the source level ANDed with its enable.
- R3: Writing offsets 0x10, 0x14 and 0x18 sets the enable of every source whose data bit is 1. These offsets cover sources 0-31, 32-63 and 64-71 respectively; offset 0x18 uses only data bits 7:0. Data bits that are 0 leave the enable unchanged. Reading one of these offsets returns the bank's current enable mask, zero-extended.
- R4: Writing offsets 0x1C, 0x20 and 0x24 clears the enable of every source whose data bit is 1. These offsets cover the same three banks in the same order. Data bits that are 0 leave the enable unchanged. These offsets read as 0.
- R5: Bit 8 of offset 0x00 is 1 when any enabled source in 0-31 is active. Bit 9 is 1 when any enabled source in 32-63 is active.
- R6: Bits 10-14 of offset 0x00 copy the enabled levels of sources 7, 9, 10, 18 and 19, lowest bit first. Bits 15-20 copy sources 53, 54, 55, 56, 57 and 62, lowest bit first. Bits 21-31 read 0.
- R7: Offset 0x0C holds an 8-bit FIQ steering value, which reads back in bits 7:0 with upper bits 0. Bit 7 arms steering and bits 6:0 name a source. `fiq_o` is high when bit 7 is set, the named source is below 72, and that source's input is high, whether or not the source is enabled. A named source of 72 or above never drives `fiq_o`.
- R8: `irq_o` is high exactly when some enabled source is active, leaving out the steered source while bit 7 of offset 0x0C is set.
- R9: Writes to offsets 0x00, 0x04, 0x08 and to any unmapped offset change no state. Reads of unmapped offsets return 0.
- R10: A register write becomes visible on reads, `irq_o` and `fiq_o` from the clock edge that accepts it. Reads are combinational on the address and the source levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | 72 | Level-sensitive interrupt request lines, numbered per R2 |
| bus_addr_i | input | 8 | Register byte offset |
| bus_we_i | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| irq_o | output | 1 | Normal interrupt request to the processor |
| fiq_o | output | 1 | Fast interrupt request to the processor |

## Verification
The assertions assume the following about the inputs:
- The write strobe, address and data are stable around the rising edge.
- The request lines are already synchronous to `clk`.
- Reset is held for at least two clock edges, so the internal release stage has filled before any check is enabled.

The stimulus respects these assumptions. It changes every input only on the falling edge, samples outputs a short time later, and holds reset for several cycles before the first bus access. The sweeps deliberately go outside the legal address range. They drive unmapped offsets, the read-only pending offsets and FIQ steering values from 72 to 127, because the design has to tolerate each of those.

// File: rtl/birq_pkg.sv
package birq_pkg;

  // Register byte offsets
  localparam int OFF_BASIC    = 'h00;
  localparam int OFF_PEND_LO  = 'h04;
  localparam int OFF_PEND_HI  = 'h08;
  localparam int OFF_FIQ      = 'h0C;
  localparam int OFF_EN_BASE  = 'h10;
  localparam int OFF_DIS_BASE = 'h1C;
  localparam int NUM_BANKS    = 3;

  // Basic status word layout
  localparam int BIT_SUM_LO = 8;
  localparam int BIT_SUM_HI = 9;
  localparam int SC_LSB     = 10;
  localparam int SC_NUM     = 11;

  // Shared source mirrored by shortcut bit SC_LSB+k
  function automatic int sc_src(input int k);
    case (k)
      0:       return 7;
      1:       return 9;
      2:       return 10;
      3:       return 18;
      4:       return 19;
      5:       return 53;
      6:       return 54;
      7:       return 55;
      8:       return 56;
      9:       return 57;
      default: return 62;
    endcase
  endfunction

endpackage

// File: rtl/birq_en_bank.sv
module birq_en_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q
);

  logic [W-1:0] en_d;
  logic         en_ce;

  assign en_ce = set_we | clr_we;

  always_comb begin
    en_d = en_q;
    if (set_we)      en_d = en_q | wdata;
    else if (clr_we) en_d = en_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((en_q & $past(wdata)) == $past(wdata))); // R3
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((en_q & $past(wdata)) == '0)); // R4
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_we || clr_we) |=> $stable(en_q)); // R9

endmodule

// File: rtl/birq_fiq_ctl.sv
module birq_fiq_ctl #(
  parameter int NUM_SRC = 72,
  parameter int SEL_W   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [SEL_W:0]     wdata,
  input  logic [NUM_SRC-1:0] src,
  output logic [SEL_W:0]     ctl_q,
  output logic [NUM_SRC-1:0] steer_mask,
  output logic               fiq_o
);

  logic [SEL_W:0] ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (we) ctl_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ctl_q <= '0;
    else if (we) ctl_q <= ctl_d;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_steer
    assign steer_mask[i] = ctl_q[SEL_W] && (ctl_q[SEL_W-1:0] == SEL_W'(i));
  end

  assign fiq_o = |(steer_mask & src);

  AST_FIQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(ctl_q)); // R7
  AST_FIQ_ONE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(steer_mask)); // R7
  AST_FIQ_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> ctl_q[SEL_W]); // R7

endmodule

// File: rtl/bank_irq_ctrl.sv
module bank_irq_ctrl
  import birq_pkg::*;
#(
  parameter int SHARED_W = 32,
  parameter int LOCAL_W  = 8,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [2*SHARED_W+LOCAL_W-1:0]      src_i,
  input  logic [ADDR_W-1:0]                  bus_addr_i,
  input  logic                               bus_we_i,
  input  logic [DATA_W-1:0]                  bus_wdata_i,
  output logic [DATA_W-1:0]                  bus_rdata_o,
  output logic                               irq_o,
  output logic                               fiq_o
);

  localparam int NUM_SRC = 2*SHARED_W + LOCAL_W;
  localparam int SEL_W   = $clog2(NUM_SRC);

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NUM_SRC-1:0] en_all;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] steer_mask;
  logic [SEL_W:0]     fiq_ctl;
  logic               fiq_we;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int BW = (b == NUM_BANKS-1) ? LOCAL_W : SHARED_W;
    localparam int LO = b * SHARED_W;
    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFF_EN_BASE + 4*b);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFF_DIS_BASE + 4*b);

    birq_en_bank #(.W(BW)) u_bank (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .set_we (bus_we_i && (bus_addr_i == A_SET)),
      .clr_we (bus_we_i && (bus_addr_i == A_CLR)),
      .wdata  (bus_wdata_i[BW-1:0]),
      .en_q   (en_all[LO +: BW])
    );
  end

  assign fiq_we = bus_we_i && (bus_addr_i == ADDR_W'(OFF_FIQ));

  birq_fiq_ctl #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_fiq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .we         (fiq_we),
    .wdata      (bus_wdata_i[SEL_W:0]),
    .src        (src_i),
    .ctl_q      (fiq_ctl),
    .steer_mask (steer_mask),
    .fiq_o      (fiq_o)
  );

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata_i;

  assign pend  = src_i & en_all;
  assign irq_o = |(pend & ~steer_mask);

  // Basic status word: local sources, bank summaries, shortcut mirrors
  logic [DATA_W-1:0] basic_w;
  always_comb begin
    basic_w = '0;
    basic_w[LOCAL_W-1:0] = pend[2*SHARED_W +: LOCAL_W];
    basic_w[BIT_SUM_LO]  = |pend[SHARED_W-1:0];
    basic_w[BIT_SUM_HI]  = |pend[SHARED_W +: SHARED_W];
    for (int k = 0; k < SC_NUM; k++) begin
      basic_w[SC_LSB+k] = pend[sc_src(k)];
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      ADDR_W'(OFF_BASIC):        bus_rdata_o = basic_w;
      ADDR_W'(OFF_PEND_LO):      bus_rdata_o = DATA_W'(pend[SHARED_W-1:0]);
      ADDR_W'(OFF_PEND_HI):      bus_rdata_o = DATA_W'(pend[SHARED_W +: SHARED_W]);
      ADDR_W'(OFF_FIQ):          bus_rdata_o = DATA_W'(fiq_ctl);
      ADDR_W'(OFF_EN_BASE):      bus_rdata_o = DATA_W'(en_all[SHARED_W-1:0]);
      ADDR_W'(OFF_EN_BASE + 4):  bus_rdata_o = DATA_W'(en_all[SHARED_W +: SHARED_W]);
      ADDR_W'(OFF_EN_BASE + 8):  bus_rdata_o = DATA_W'(en_all[2*SHARED_W +: LOCAL_W]);
      default:                   bus_rdata_o = '0;
    endcase
  end

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_o |-> |(src_i & en_all)); // R8
  AST_SUMMARY_BACKED: assert property (@(posedge clk) disable iff (!rst_int_n)
    (basic_w[BIT_SUM_LO] || basic_w[BIT_SUM_HI]) |-> |src_i[2*SHARED_W-1:0]); // R5
  AST_FIQ_SRC_HIGH: assert property (@(posedge clk) disable iff (!rst_int_n)
    fiq_o |-> |src_i); // R7

endmodule

// File: tb/tb_bank_irq_ctrl.sv
`timescale 1ns/1ps
module tb_bank_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [71:0] src;
  logic [7:0]  addr;
  logic        we;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq, fiq;

  logic [71:0] en_m;
  logic [7:0]  fiq_m;
  logic [31:0] seed;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  bank_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  function automatic [31:0] exp_rd(input [7:0] a);
    logic [71:0] p;
    p = src & en_m;
    case (a)
      8'h00: exp_rd = {11'b0, p[62], p[57:53], p[19], p[18], p[10], p[9], p[7],
                       |p[63:32], |p[31:0], p[71:64]};
      8'h04: exp_rd = p[31:0];
      8'h08: exp_rd = p[63:32];
      8'h0C: exp_rd = {24'b0, fiq_m};
      8'h10: exp_rd = en_m[31:0];
      8'h14: exp_rd = en_m[63:32];
      8'h18: exp_rd = {24'b0, en_m[71:64]};
      default: exp_rd = 32'b0;
    endcase
  endfunction

  function automatic logic exp_irq();
    logic [71:0] msk;
    msk = fiq_m[7] ? (72'b1 << fiq_m[6:0]) : 72'b0;
    exp_irq = |(src & en_m & ~msk);
  endfunction

  function automatic logic exp_fiq();
    exp_fiq = fiq_m[7] && (fiq_m[6:0] < 7'd72) && src[fiq_m[6:0]];
  endfunction

  function automatic [31:0] xs(input [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    xs = y ^ (y << 5);
  endfunction

  task automatic chk(input string tag, input [31:0] act, input [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input [7:0] a, input [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    if (a >= 8'h10 && a <= 8'h18 && a[1:0] == 2'b00) begin
      case (a)
        8'h10: en_m[31:0]  = en_m[31:0]  | d;
        8'h14: en_m[63:32] = en_m[63:32] | d;
        default: en_m[71:64] = en_m[71:64] | d[7:0];
      endcase
    end else if (a == 8'h1C) en_m[31:0]  = en_m[31:0]  & ~d;
    else if (a == 8'h20)     en_m[63:32] = en_m[63:32] & ~d;
    else if (a == 8'h24)     en_m[71:64] = en_m[71:64] & ~d[7:0];
    else if (a == 8'h0C)     fiq_m = d[7:0];
  endtask

  task automatic rdchk(input [7:0] a, input string tag);
    @(negedge clk);
    addr = a; we = 1'b0;
    #2;
    chk(tag, rdata, exp_rd(a));
  endtask

  task automatic outchk();
    #2;
    chk("R8 irq_o", {31'b0, irq}, {31'b0, exp_irq()});
    chk("R7 fiq_o", {31'b0, fiq}, {31'b0, exp_fiq()});
  endtask

  task automatic set_src(input [71:0] v);
    @(negedge clk);
    src = v;
  endtask

  task automatic full_chk();
    rdchk(8'h00, "R6 basic word");
    chk("R5 summary bits", {30'b0, rdata[9:8]}, {30'b0, exp_rd(8'h00) >> 8} & 32'h3);
    rdchk(8'h04, "R2 pending low bank");
    rdchk(8'h08, "R2 pending high bank");
    rdchk(8'h0C, "R7 steering readback");
    rdchk(8'h10, "R3 enable readback");
    rdchk(8'h14, "R3 enable readback");
    rdchk(8'h18, "R3 enable readback");
    rdchk(8'h20, "R4 disable offset reads 0");
    rdchk(8'h30, "R9 unmapped read");
    outchk();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    src = '0; addr = '0; we = 1'b0; wdata = '0;
    en_m = '0; fiq_m = '0; seed = 32'h1234_5678;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state with all sources active
    set_src({72{1'b1}});
    for (int a = 0; a < 10; a++) begin
      rdchk(8'(4*a), "R1 reset read");
    end
    outchk();
    chk("R1 irq after reset", {31'b0, irq}, 32'b0);

    // R10: write visible from the accepting edge
    @(negedge clk);
    addr = 8'h10; wdata = 32'h0000_0081; we = 1'b1;
    #2 chk("R10 before edge", rdata, 32'h0);
    @(posedge clk); #2;
    chk("R10 after edge", rdata, 32'h0000_0081);
    @(negedge clk) we = 1'b0;
    en_m[31:0] = 32'h81;
    wr(8'h1C, 32'h0000_0081);

    // R2/R5/R6/R8: one source at a time, all enabled
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    for (int s = 0; s < 72; s++) begin
      set_src(72'b1 << s);
      rdchk(8'h00, "R6 basic single source");
      rdchk(8'h04, "R2 single source low");
      rdchk(8'h08, "R2 single source high");
      outchk();
    end

    // R4: clear with zero data is no-op, then partial clears
    wr(8'h20, 32'h0);
    set_src({72{1'b1}});
    full_chk();
    wr(8'h1C, 32'hA5A5_0F0F);
    wr(8'h24, 32'hFFFF_FF0F);
    full_chk();

    // R9: writes to read-only and unmapped offsets
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h04, 32'h0);
    wr(8'h08, 32'h1234_5678);
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h11, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    full_chk();

    // R7/R8: steering sweep over all 128 selector values
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFF);
    for (int sel = 0; sel < 128; sel++) begin
      wr(8'h0C, 32'h80 | sel);
      rdchk(8'h0C, "R7 steering readback");
      set_src(sel < 72 ? (72'b1 << sel) : 72'b0);
      outchk();
      set_src({72{1'b1}});
      outchk();
    end
    // R7: steered source ignores its enable
    wr(8'h0C, 32'h85);
    wr(8'h1C, 32'hFFFF_FFFF);
    set_src(72'b1 << 5);
    outchk();
    wr(8'h0C, 32'h05);
    outchk();

    // Mixed random traffic against the model
    for (int it = 0; it < 300; it++) begin
      logic [31:0] r;
      seed = xs(seed); r = seed;
      seed = xs(seed);
      case (r % 6)
        0: wr(8'h10 + 8'(4 * (r[5:4] % 3)), seed);
        1: wr(8'h1C + 8'(4 * (r[5:4] % 3)), seed);
        2: wr((r[6] ? 8'h04 : 8'h2C), seed);
        3: set_src({seed[7:0], xs(seed), seed});
        4: wr(8'h0C, {24'b0, seed[7:0]});
        default: set_src({seed[15:8], seed, xs(seed)});
      endcase
      full_chk();
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule